// File: doc/BRIEF.md
# CAN Message Buffer Interrupt Flag Register

This block holds the completion flags of a CAN controller's 32 message buffers. Each flag is set by a one-cycle pulse from the buffer engine and cleared by software. Software writes a word in which every 1 bit clears the matching flag. A read port returns the flag word, and a masked OR of the flags drives one interrupt request line.

The low byte changes meaning when the receive FIFO is switched on. In that mode three of its positions report FIFO conditions: an overflow that lost a frame, an almost-full warning, and a frame waiting to be read. The five lowest positions go quiet. Whenever the FIFO-enable input changes value, the low byte is wiped so that no flag carries over from the old meaning. The FIFO storage, the protocol engine and the buffer memory sit outside this block.

Top module: `can_mb_flag_reg`

## Requirements
- R1: Synchronous active-high reset drives the flag word, the interrupt request and the read data to zero. Reset also sets the block's record of the FIFO mode to disabled.
- R2: A high `buf_done_i[n]` for n in 31..8 sets flag n at that clock edge. The flag is visible on `flags_o` after the edge, whatever the FIFO mode.
- R3: A write (`wr_en_i` high) clears every flag whose position holds 1 in `wr_data_i`. Positions holding 0 keep their value.
- R4: If a set source and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R5: With `fifo_en_i` low, `buf_done_i[7:0]` set flags 7..0 in the same way as R2. In this mode the three FIFO status inputs have no effect.
- R6: With `fifo_en_i` high, bit 7 is set by `fifo_ovf_i` (frame lost, FIFO full). Bit 6 is set by `fifo_warn_i` (5 of 6 slots used). Bit 5 is set on every cycle in which `fifo_avail_i` is high. `buf_done_i[7:5]` are ignored in this mode.
- R7: With `fifo_en_i` high, flags 4..0 never set, and `buf_done_i[4:0]` are ignored.
- R8: On any cycle where `fifo_en_i` differs from the mode recorded at the previous edge, flags 7..0 become zero at that edge, even if a set source is active. Flags 31..8 follow R2/R3 as usual.
- R9: `irq_o` is registered. After each edge it equals the OR over all n of (flag n AND `mask_i[n]`), evaluated on the flag word and mask present before that edge.
- R10: When `rd_en_i` is high at an edge, `rd_data_o` captures the flag word present before that edge and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en_i | input | 1 | Receive FIFO enabled |
| buf_done_i | input | 32 | Per-buffer completion pulses |
| fifo_ovf_i | input | 1 | FIFO overflow event |
| fifo_warn_i | input | 1 | FIFO almost-full event |
| fifo_avail_i | input | 1 | FIFO holds at least one frame |
| wr_en_i | input | 1 | Write-one-to-clear strobe |
| wr_data_i | input | 32 | Clear pattern |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| mask_i | input | 32 | Interrupt enable per flag |
| flags_o | output | 32 | Current flag word |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions can happen in one cycle. A set source can meet a write-one clear on the same bit, and a FIFO-mode switch can meet a set on the low byte. The bench drives each buffer pulse together with a clear of that same bit. It also holds the frame-available level while clearing bit 5 on every cycle, and it toggles the mode in the same cycle as buffer and FIFO events. The bench judges each outcome against its own model of the next flag word: set wins over clear, and a mode switch wins over both.

// File: rtl/can_iflag_pkg.sv
package can_iflag_pkg;
  localparam int LOW_W     = 8;
  localparam int OVF_POS   = 7;
  localparam int WARN_POS  = 6;
  localparam int AVAIL_POS = 5;

  typedef struct packed {
    logic ovf;
    logic warn;
    logic avail;
  } fifo_evt_t;
endpackage

// File: rtl/can_iflag_router.sv
module can_iflag_router
  import can_iflag_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic               fifo_en_i,
  input  logic [NUM_BUF-1:0] buf_done_i,
  input  fifo_evt_t          evt_i,
  output logic [NUM_BUF-1:0] set_o
);
  // Per-bit source selection: upper positions always track the buffer
  // pulses, the low byte is remapped when the FIFO is on.
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_bit
    if (i >= LOW_W) begin : g_upper
      assign set_o[i] = buf_done_i[i];
    end else if (i == OVF_POS) begin : g_ovf
      assign set_o[i] = fifo_en_i ? evt_i.ovf : buf_done_i[i];
    end else if (i == WARN_POS) begin : g_warn
      assign set_o[i] = fifo_en_i ? evt_i.warn : buf_done_i[i];
    end else if (i == AVAIL_POS) begin : g_avail
      assign set_o[i] = fifo_en_i ? evt_i.avail : buf_done_i[i];
    end else begin : g_rsvd
      assign set_o[i] = fifo_en_i ? 1'b0 : buf_done_i[i];
    end
  end
endmodule

// File: rtl/can_iflag_bank.sv
module can_iflag_bank
  import can_iflag_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] set_i,
  input  logic [NUM_BUF-1:0] clr_i,
  input  logic               low_wipe_i,
  output logic [NUM_BUF-1:0] flags_o
);
  logic [NUM_BUF-1:0] flags_q;
  logic [NUM_BUF-1:0] flags_d;

  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
    if (low_wipe_i) flags_d[LOW_W-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_chk
    if (i >= LOW_W) begin : g_hi
      a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> flags_q[i]);
      a_r3_clear_hits: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    end else begin : g_lo
      a_r4_set_wins_lo: assert property (@(posedge clk) disable iff (rst)
        (set_i[i] && !low_wipe_i) |=> flags_q[i]);
      a_r3_clear_hits_lo: assert property (@(posedge clk) disable iff (rst)
        (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    end
  end

  a_r8_low_wiped: assert property (@(posedge clk) disable iff (rst)
    low_wipe_i |=> (flags_q[LOW_W-1:0] == '0));
endmodule

// File: rtl/can_iflag_irq.sv
module can_iflag_irq #(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] flags_i,
  input  logic [NUM_BUF-1:0] mask_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_i & mask_i);
  end

  assign irq_o = irq_q;

  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    ((flags_i & mask_i) != '0) |=> irq_o);
  a_r9_irq_drop: assert property (@(posedge clk) disable iff (rst)
    ((flags_i & mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/can_mb_flag_reg.sv
module can_mb_flag_reg
  import can_iflag_pkg::*;
#(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en_i,
  input  logic [NUM_BUF-1:0] buf_done_i,
  input  logic               fifo_ovf_i,
  input  logic               fifo_warn_i,
  input  logic               fifo_avail_i,
  input  logic               wr_en_i,
  input  logic [NUM_BUF-1:0] wr_data_i,
  input  logic               rd_en_i,
  output logic [NUM_BUF-1:0] rd_data_o,
  input  logic [NUM_BUF-1:0] mask_i,
  output logic [NUM_BUF-1:0] flags_o,
  output logic               irq_o
);
  localparam int RSVD_W = AVAIL_POS;

  logic               mode_q;
  logic               mode_chg;
  fifo_evt_t          evt;
  logic [NUM_BUF-1:0] set_vec;
  logic [NUM_BUF-1:0] clr_vec;
  logic [NUM_BUF-1:0] flags;
  logic [NUM_BUF-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_en_i;
  end

  assign mode_chg  = fifo_en_i ^ mode_q;
  assign evt.ovf   = fifo_ovf_i;
  assign evt.warn  = fifo_warn_i;
  assign evt.avail = fifo_avail_i;
  assign clr_vec   = wr_en_i ? wr_data_i : '0;

  can_iflag_router #(.NUM_BUF(NUM_BUF)) router_i (
    .fifo_en_i (fifo_en_i),
    .buf_done_i(buf_done_i),
    .evt_i     (evt),
    .set_o     (set_vec)
  );

  can_iflag_bank #(.NUM_BUF(NUM_BUF)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .low_wipe_i(mode_chg),
    .flags_o   (flags)
  );

  can_iflag_irq #(.NUM_BUF(NUM_BUF)) irq_i (
    .clk    (clk),
    .rst    (rst),
    .flags_i(flags),
    .mask_i (mask_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= flags;
  end

  assign rd_data_o = rd_q;
  assign flags_o   = flags;

  a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && mode_q) |=> (flags[RSVD_W-1:0] == '0));
  a_r6_overflow_sets: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && mode_q && fifo_ovf_i) |=> flags[OVF_POS]);
  a_r6_avail_sets: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_i && mode_q && fifo_avail_i) |=> flags[AVAIL_POS]);
  a_r10_read_capture: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> (rd_data_o == $past(flags)));
  a_r2_upper_sets: assert property (@(posedge clk) disable iff (rst)
    buf_done_i[NUM_BUF-1] |=> flags[NUM_BUF-1]);
endmodule

// File: tb/can_mb_flag_reg_tb.sv
module can_mb_flag_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fifo_en = 1'b0;
  logic [NB-1:0] done = '0;
  logic          ovf = 1'b0, warn = 1'b0, avail = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [NB-1:0] wdata = '0;
  logic [NB-1:0] mask = '1;
  logic [NB-1:0] rdata, flags;
  logic          irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [NB-1:0] exp_flags = '0, exp_rd = '0;
  logic          exp_irq = 1'b0, exp_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mb_flag_reg #(.NUM_BUF(NB)) dut_i (
    .clk(clk), .rst(rst), .fifo_en_i(fifo_en), .buf_done_i(done),
    .fifo_ovf_i(ovf), .fifo_warn_i(warn), .fifo_avail_i(avail),
    .wr_en_i(wr), .wr_data_i(wdata), .rd_en_i(rd), .rd_data_o(rdata),
    .mask_i(mask), .flags_o(flags), .irq_o(irq)
  );

  task automatic check(string tag, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: predict from the requirements, advance, compare, drop pulses.
  task automatic step(string tag);
    logic [NB-1:0] s, n;
    s = fifo_en ? ((done & 32'hFFFF_FF00) | ({31'b0, ovf} << 7) |
                   ({31'b0, warn} << 6) | ({31'b0, avail} << 5)) : done;
    n = (exp_flags & ~(wr ? wdata : '0)) | s;
    if (fifo_en != exp_mode) n[7:0] = '0;
    exp_irq = |(exp_flags & mask);
    if (rd) exp_rd = exp_flags;
    exp_flags = n;
    exp_mode = fifo_en;
    @(posedge clk);
    @(negedge clk);
    check(tag, "flags", flags, exp_flags);
    check("R9", "irq", {31'b0, irq}, {31'b0, exp_irq});
    check("R10", "rd_data", rdata, exp_rd);
    done = '0; ovf = 0; warn = 0; avail = 0; wr = 0; wdata = '0; rd = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "flags", flags, '0);
    check("R1", "irq", {31'b0, irq}, '0);
    check("R1", "rd_data", rdata, '0);

    // FIFO off: every position sets, a zero write is ignored, a one write clears.
    for (int i = 0; i < NB; i++) begin
      done = NB'(1) << i;
      step(i >= 8 ? "R2" : "R5");
      wr = 1; wdata = '0; rd = 1;
      step("R3");
      wr = 1; wdata = NB'(1) << i;
      step("R3");
      step("R9");
    end

    // Set and clear on the same bit in the same cycle.
    for (int i = 0; i < NB; i++) begin
      done = NB'(1) << i; wr = 1; wdata = NB'(1) << i;
      step("R4");
      wr = 1; wdata = '1; rd = 1;
      step("R3");
    end

    // Masked interrupt, one mask bit at a time.
    done = '1;
    step("R2");
    for (int k = 0; k < NB; k++) begin
      mask = NB'(1) << k;
      step("R9");
    end
    mask = '0;
    step("R9");
    step("R9");
    mask = '1;

    // Enter FIFO mode with a buffer pulse in the same cycle.
    fifo_en = 1; done = '1; rd = 1;
    step("R8");
    done = '1;
    step("R7");
    wr = 1; wdata = '1;
    step("R3");
    ovf = 1;
    step("R6");
    warn = 1;
    step("R6");
    for (int c = 0; c < 3; c++) begin
      avail = 1; wr = 1; wdata = 32'h20;
      step("R6");
    end
    wr = 1; wdata = 32'h20;
    step("R3");
    done = 32'h0000_00FF;
    step("R7");
    // Leave FIFO mode with FIFO flags set.
    ovf = 1; warn = 1;
    step("R6");
    fifo_en = 0; done = 32'h0100_00FF; ovf = 1;
    step("R8");
    ovf = 1; warn = 1; avail = 1;
    step("R5");
    done = 32'h0000_001F;
    step("R5");
    fifo_en = 1; wr = 1; wdata = 32'h0100_0000;
    step("R8");
    fifo_en = 0;
    step("R8");
    rd = 1;
    step("R10");
    step("R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule